// File: doc/BRIEF.md
# Expansion Bank Chunk Ownership Unit

The processor address space is split into eight 8 KB chunks, picked by the top three address bits. Each expansion bank on the backplane holds one copy of this unit. The unit records which chunks the bank has taken over, and it raises the memory enable when the processor touches one of those chunks.

Software reaches the unit by writing bytes to a small set of bank-switching register codes. The register code is the same three-bit value that would appear on the top three address lines. Several writes reach every bank at once:

- a shared "target bank" number,
- a global strip mask that takes chunks away from all banks.

Only a write to the ownership register is gated: it lands in a bank only when the target bank number equals that bank's own identity number. The identity number is loaded once during the daisy-chain setup phase. The bank that holds the chain token takes it from the strip-mask register code.

Reads of a register pair are answered only by the bank that is currently targeted, so software can read back ownership and check that a bank is present. The output enable for the read pads is produced as a separate signal, and the pad driver is tri-stated whenever that signal is low. A high-true bus-isolate input takes the bank off the memory bus whatever its ownership says.

Top module: `xbank_owner`

## Requirements
- R1: A synchronous reset clears the target bank number, the identity number and the ownership mask to zero, so after reset the bank claims no chunk.
- R2: A write with register code 4 (address 0x80) loads the target bank number, whatever the identity number is.
- R3: A write with register code 2 (address 0x40) loads the ownership mask only when the target bank number equals the identity number. Otherwise the write leaves the mask unchanged.
- R4: With `setup_mode` low, a write with register code 5 (address 0xA0) clears every ownership bit that is 1 in the written byte and keeps the bits that are 0. No bank-number match is needed.
- R5: With `setup_mode` high, a code-5 write loads the identity number if `chain_tok` is high and is dropped if `chain_tok` is low. In either case it leaves the ownership mask unchanged.
- R6: `mem_en` is high when `ioa5` is high, `bus_iso` is low and ownership bit n is set, where n is `addr_hi` read as an unsigned number. The memory-request strobe plays no part.
- R7: With the code-chunk option enabled (default chunks 3 and 7), `mem_en` is also high when `ioa5` is low, the chunk is one of those and is owned, and `bus_iso` is low. For any other chunk, `mem_en` stays low while `ioa5` is low.
- R8: While `bus_iso` is high, `mem_en` and `bank_claim` are both low.
- R9: `rd_oe` is high when `rd_en` is high and the target number equals the identity number. With `rd_pair` = 1 (the 0x80/0x40 pair), `rd_data` then equals the ownership mask.
- R10: With `rd_oe` high and `rd_pair` = 0 (the 0xC0/0xA0 pair), `rd_data` is 0x00. Bit 2 low marks the bank as present.
- R11: When there is no number match, or `rd_en` is low, `rd_oe` is low and `rd_data` is 0x00.
- R12: `bank_claim` is high when the chunk indexed by `addr_hi` is owned and `bus_iso` is low, whatever the level of `ioa5`.
- R13: Writes with register codes 0, 1, 3, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle pulse: a reassembled register byte is ready |
| wr_reg | input | 3 | Register code of the write (address bits 15..13 of the register) |
| wr_data | input | 8 | Written byte |
| setup_mode | input | 1 | High while the daisy-chain setup phase is active |
| chain_tok | input | 1 | High when this bank holds the daisy-chain token |
| addr_hi | input | 3 | Processor address bits 15..13 (chunk index) |
| ioa5 | input | 1 | High for memory cycles, low while register access is enabled |
| bus_iso | input | 1 | High-true isolate: removes the bank from the bus |
| rd_en | input | 1 | Register-pair read in progress |
| rd_pair | input | 1 | 1 selects the 0x80/0x40 pair, 0 selects the 0xC0/0xA0 pair |
| mem_en | output | 1 | Memory enable for this bank's array |
| bank_claim | output | 1 | Bank owns the current chunk; drives the open-collector bank-enable line |
| rd_oe | output | 1 | Read-pad output enable (pads are tri-stated when low) |
| rd_data | output | 8 | Register-pair read data |

## Verification
On every clock edge the assertions check the write-side rules:

- the target number loads unconditionally;
- the ownership mask stays unchanged on an unmatched ownership write, on a setup-phase write and on a write to an unused code;
- no stripped bit survives a strip-mask write.

They also check that isolation forces both enables low, that `mem_en` never rises without `bank_claim`, and that the read enable needs `rd_en`.

Some behaviour only the bench's scenarios can show, through its reference model:

- whether the identity number was actually taken from a token-holding setup write;
- the exact enable level in each of the eight chunks for both `ioa5` levels;
- the byte returned for each read pair.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

    localparam int ADDR_W  = 3;
    localparam int NCHUNK  = 1 << ADDR_W;
    localparam int DATA_W  = NCHUNK;
    localparam int BANK_W  = DATA_W;

    typedef logic [ADDR_W-1:0] chunk_t;
    typedef logic [NCHUNK-1:0] cmask_t;
    typedef logic [BANK_W-1:0] bank_t;

    // Register codes equal the top three address bits of the register
    typedef enum logic [ADDR_W-1:0] {
        RSEL_OWN    = 3'd2,   // 0x40 ownership mask (gated by number match)
        RSEL_TARGET = 3'd4,   // 0x80 target bank number (all banks)
        RSEL_STRIP  = 3'd5,   // 0xA0 strip mask / identity load in setup
        RSEL_MODE   = 3'd6    // 0xC0 mode control, handled outside this unit
    } rsel_e;

    typedef struct packed {
        bank_t  target;
        bank_t  ident;
        cmask_t own;
    } bank_state_t;

    localparam bank_state_t STATE_RESET = '0;

    // Value returned for the mode/strip pair; bit 2 low flags presence
    localparam logic [DATA_W-1:0] PRESENT_WORD = '0;

    function automatic logic chunk_owned(cmask_t m, chunk_t c);
        return m[c];
    endfunction

endpackage

// File: rtl/xbank_regs.sv
module xbank_regs
    import xbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_stb,
    input  logic [ADDR_W-1:0]    wr_reg,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 setup_mode,
    input  logic                 chain_tok,
    output bank_state_t          st,
    output logic                 num_match
);

    bank_state_t st_nx;
    logic        hit_target, hit_own, hit_strip;

    assign hit_target = wr_stb && (wr_reg == RSEL_TARGET);
    assign hit_own    = wr_stb && (wr_reg == RSEL_OWN);
    assign hit_strip  = wr_stb && (wr_reg == RSEL_STRIP);
    assign num_match  = (st.target == st.ident);

    always_comb begin
        st_nx = st;
        if (hit_target)
            st_nx.target = bank_t'(wr_data);
        if (hit_own && num_match)
            st_nx.own = cmask_t'(wr_data);
        if (hit_strip) begin
            if (setup_mode) begin
                if (chain_tok)
                    st_nx.ident = bank_t'(wr_data);
            end else begin
                st_nx.own = st.own & ~cmask_t'(wr_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= STATE_RESET;
        else     st <= st_nx;
    end

    // R1: reset empties ownership
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (st.own == '0 && st.target == '0 && st.ident == '0));

    // R2: target number loads in every bank
    p_target_load_r2: assert property (@(posedge clk) disable iff (rst)
        hit_target |=> st.target == bank_t'($past(wr_data)));

    // R3: ownership write without match is dropped
    p_own_guard_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_own && st.target != st.ident) |=> $stable(st.own));

    // R4: strip mask leaves no stripped bit set
    p_strip_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (hit_strip && !setup_mode) |=> ((st.own & cmask_t'($past(wr_data))) == '0));

    // R5: setup-phase write never touches ownership
    p_setup_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (hit_strip && setup_mode) |=> $stable(st.own));

    // R13: unused register codes change nothing
    p_unused_code_r13: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !(wr_reg inside {RSEL_OWN, RSEL_TARGET, RSEL_STRIP})) |=> $stable(st));

endmodule

// File: rtl/xbank_decode.sv
module xbank_decode
    import xbank_pkg::*;
#(
    parameter logic [NCHUNK-1:0] CODE_MASK = 8'h88,
    parameter bit                CODE_RUN  = 1'b1
) (
    input  cmask_t  own,
    input  chunk_t  addr_hi,
    input  logic    ioa5,
    input  logic    bus_iso,
    output logic    mem_en,
    output logic    bank_claim
);

    logic owned, code_ok;

    assign owned = chunk_owned(own, addr_hi);

    generate
        if (CODE_RUN) begin : g_code_run
            assign code_ok = CODE_MASK[addr_hi];
        end else begin : g_no_code_run
            assign code_ok = 1'b0;
        end
    endgenerate

    assign bank_claim = owned && !bus_iso;
    assign mem_en     = owned && !bus_iso && (ioa5 || code_ok);

endmodule

// File: rtl/xbank_readback.sv
module xbank_readback
    import xbank_pkg::*;
(
    input  logic               rd_en,
    input  logic               rd_pair,
    input  logic               num_match,
    input  cmask_t             own,
    output logic               rd_oe,
    output logic [DATA_W-1:0]  rd_data
);

    assign rd_oe = rd_en && num_match;

    always_comb begin
        if (!rd_oe)       rd_data = '0;
        else if (rd_pair) rd_data = DATA_W'(own);
        else              rd_data = PRESENT_WORD;
    end

endmodule

// File: rtl/xbank_owner.sv
module xbank_owner
    import xbank_pkg::*;
#(
    parameter logic [NCHUNK-1:0] CODE_MASK = 8'h88,
    parameter bit                CODE_RUN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic [ADDR_W-1:0]  wr_reg,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               setup_mode,
    input  logic               chain_tok,
    input  logic [ADDR_W-1:0]  addr_hi,
    input  logic               ioa5,
    input  logic               bus_iso,
    input  logic               rd_en,
    input  logic               rd_pair,
    output logic               mem_en,
    output logic               bank_claim,
    output logic               rd_oe,
    output logic [DATA_W-1:0]  rd_data
);

    bank_state_t st;
    logic        num_match;

    xbank_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_reg     (wr_reg),
        .wr_data    (wr_data),
        .setup_mode (setup_mode),
        .chain_tok  (chain_tok),
        .st         (st),
        .num_match  (num_match)
    );

    xbank_decode #(
        .CODE_MASK (CODE_MASK),
        .CODE_RUN  (CODE_RUN)
    ) u_decode (
        .own        (st.own),
        .addr_hi    (addr_hi),
        .ioa5       (ioa5),
        .bus_iso    (bus_iso),
        .mem_en     (mem_en),
        .bank_claim (bank_claim)
    );

    xbank_readback u_rdbk (
        .rd_en     (rd_en),
        .rd_pair   (rd_pair),
        .num_match (num_match),
        .own       (st.own),
        .rd_oe     (rd_oe),
        .rd_data   (rd_data)
    );

    // R8: isolation silences both enables
    p_iso_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        bus_iso |-> (!mem_en && !bank_claim));

    // R6: memory enable only for a claimed chunk
    p_en_needs_claim_r6: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> bank_claim);

    // R11: pads are driven only during a read
    p_oe_needs_rd_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (!rd_oe && rd_data == '0));

endmodule

// File: tb/sim_xbank_owner.sv
module sim_xbank_owner;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [2:0] wr_reg = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       setup_mode = 1'b0;
    logic       chain_tok = 1'b0;
    logic [2:0] addr_hi = 3'd0;
    logic       ioa5 = 1'b1;
    logic       bus_iso = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_pair = 1'b0;
    logic       mem_en, bank_claim, rd_oe;
    logic [7:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference state
    int m_target = 0;
    int m_ident  = 0;
    int m_own    = 0;

    always #10 clk = ~clk;   // 50 MHz

    xbank_owner u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_reg(wr_reg), .wr_data(wr_data),
        .setup_mode(setup_mode), .chain_tok(chain_tok), .addr_hi(addr_hi),
        .ioa5(ioa5), .bus_iso(bus_iso), .rd_en(rd_en), .rd_pair(rd_pair),
        .mem_en(mem_en), .bank_claim(bank_claim), .rd_oe(rd_oe), .rd_data(rd_data)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // compare every output against the model, then clock and update model
    task automatic step(string tag);
        int owned, code, e_en, e_claim, e_oe, e_rd;
        #5;
        owned   = (m_own >> addr_hi) & 1;
        code    = (addr_hi == 3 || addr_hi == 7) ? 1 : 0;
        e_claim = (owned && !bus_iso) ? 1 : 0;
        e_en    = (owned && !bus_iso && (ioa5 || code)) ? 1 : 0;
        e_oe    = (rd_en && m_target == m_ident) ? 1 : 0;
        e_rd    = e_oe ? (rd_pair ? m_own : 0) : 0;
        cmp(tag, "mem_en", int'(mem_en), e_en);
        cmp(tag, "bank_claim", int'(bank_claim), e_claim);
        cmp(tag, "rd_oe", int'(rd_oe), e_oe);
        cmp(tag, "rd_data", int'(rd_data), e_rd);
        @(posedge clk);
        if (rst) begin
            m_target = 0; m_ident = 0; m_own = 0;
        end else if (wr_stb) begin
            case (wr_reg)
                3'd4: m_target = wr_data;
                3'd2: if (m_target == m_ident) m_own = wr_data;
                3'd5: if (setup_mode) begin
                          if (chain_tok) m_ident = wr_data;
                      end else m_own = m_own & ~int'(wr_data);
                default: ;
            endcase
        end
        @(negedge clk);
        wr_stb = 1'b0;
        rd_en  = 1'b0;
    endtask

    task automatic wr(string tag, logic [2:0] r, logic [7:0] d);
        wr_stb = 1'b1; wr_reg = r; wr_data = d;
        step(tag);
    endtask

    task automatic rd(string tag, logic pair);
        rd_en = 1'b1; rd_pair = pair;
        step(tag);
    endtask

    task automatic sweep(string tag, logic io);
        ioa5 = io;
        for (int c = 0; c < 8; c++) begin
            addr_hi = 3'(c);
            step(tag);
        end
        ioa5 = 1'b1;
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        step("R1");
        step("R1");
        rst = 1'b0;
        // R1: state after reset: nothing owned, match on zero numbers
        sweep("R1", 1'b1);
        rd("R1", 1'b1);

        // R2: target loads; R3: unmatched ownership write dropped
        wr("R2", 3'd4, 8'h05);
        wr("R3", 3'd2, 8'hFF);
        sweep("R3", 1'b1);
        rd("R11", 1'b1);

        // R5: setup write without token dropped, with token loads identity
        setup_mode = 1'b1;
        wr("R5", 3'd5, 8'h05);
        rd("R5", 1'b1);
        chain_tok = 1'b1;
        wr("R5", 3'd5, 8'h05);
        chain_tok = 1'b0;
        setup_mode = 1'b0;
        rd("R5", 1'b0);

        // R3: matched ownership write; R6/R7/R12 chunk sweeps
        wr("R3", 3'd2, 8'hA9);
        sweep("R6", 1'b1);
        sweep("R7", 1'b0);
        sweep("R12", 1'b0);

        // R9/R10 reads; R11 mismatch
        rd("R9", 1'b1);
        rd("R10", 1'b0);
        wr("R2", 3'd4, 8'h06);
        rd("R11", 1'b1);
        rd("R11", 1'b0);

        // R4: strip without match
        wr("R4", 3'd5, 8'h21);
        wr("R2", 3'd4, 8'h05);
        rd("R4", 1'b1);
        sweep("R4", 1'b1);

        // R5: setup write with token keeps ownership
        setup_mode = 1'b1; chain_tok = 1'b1;
        wr("R5", 3'd5, 8'h05);
        setup_mode = 1'b0; chain_tok = 1'b0;
        rd("R5", 1'b1);

        // R8: isolation
        bus_iso = 1'b1;
        sweep("R8", 1'b1);
        sweep("R8", 1'b0);
        bus_iso = 1'b0;

        // R13: unused codes
        wr("R13", 3'd6, 8'hFF);
        wr("R13", 3'd0, 8'hFF);
        wr("R13", 3'd1, 8'h00);
        wr("R13", 3'd3, 8'hFF);
        wr("R13", 3'd7, 8'hFF);
        rd("R13", 1'b1);
        sweep("R13", 1'b1);

        // mixed traffic, checked by the model every cycle
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_stb     = lfsr[0];
            wr_reg     = lfsr[3:1];
            wr_data    = {lfsr[11:9], lfsr[6:5], 3'b000} | {5'd0, lfsr[14:12]};
            setup_mode = (lfsr[15:13] == 3'b111);
            chain_tok  = lfsr[8];
            addr_hi    = lfsr[7:5];
            ioa5       = lfsr[4];
            bus_iso    = (lfsr[11:10] == 2'b11);
            rd_en      = lfsr[9];
            rd_pair    = lfsr[2];
            step("R6");
        end
        setup_mode = 1'b0; bus_iso = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule